// File: doc/BRIEF.md
# Integer Execute Stage for a Small RISC Subset

This block decodes a raw 32-bit instruction word and computes its result. It handles a short integer subset: two register-register adds (one trapping, one wrapping), a trapping add with an immediate, bitwise OR and XOR in register and immediate forms, and a load of an immediate into the upper half of a register. The caller reads the two source registers named by the word and presents their contents with it. One clock later the stage reports a result, a write enable and a destination index for the register file, and a one-cycle overflow flag for the exception logic.

The immediate field is 16 bits wide. A 32-bit constant therefore takes two instructions: an upper-half load, then an OR-immediate of the low half into the same register. Arithmetic immediates are sign-extended. Logical immediates are zero-extended. Any word the stage does not recognise, including the all-zero no-operation word, leaves no trace. A write aimed at register 0 is dropped.

Top module: `xu_exec`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: Outputs are registered with one cycle of latency. A cycle with `in_valid` low gives `wr_en` and `ovf` low on the next cycle, whatever is on `instr`.
- R3: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and imm [15:0]. Register-register forms (opcode 0x00) write rd. Immediate forms write rt.
- R4: Opcode 0x00 with funct 0x20 gives rs+rt as a signed add and raises overflow on signed overflow.
- R5: Opcode 0x00 with funct 0x21 gives rs+rt modulo 2^32 and never raises overflow.
- R6: Opcode 0x08 gives rs plus the sign-extended imm and raises overflow on signed overflow.
- R7: Opcode 0x00 with funct 0x25 gives rs OR rt. Opcode 0x00 with funct 0x26 gives rs XOR rt.
- R8: Opcode 0x0D gives rs OR the zero-extended imm.
- R9: Opcode 0x0F gives imm in bits 31..16 and zero in bits 15..0. Following it with opcode 0x0D on the same register builds any 32-bit constant.
- R10: An overflowing add suppresses the write and raises `ovf` for exactly one cycle.
- R11: A result whose destination index is 0 is discarded (`wr_en` low). Overflow is still flagged.
- R12: An unrecognised word, including the all-zero no-operation word, gives no write and no overflow.
- R13: Whenever `wr_en` is low, `wr_data` and `wr_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Raw instruction word |
| rs_data | input | 32 | Contents of the register named by the rs field |
| rt_data | input | 32 | Contents of the register named by the rt field |
| wr_en | output | 1 | Register file write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Value to write |
| ovf | output | 1 | Signed overflow on a trapping add, one cycle |

## Verification
Overflow detection and the register-0 discard can act in the same cycle. Both suppress the write, yet only overflow may raise the flag. The bench issues a trapping add of 0x7FFFFFFF and 1 with rd set to 0. It expects the flag high with no write, and then the flag low on the following idle cycle. It also issues a non-overflowing upper-half load to register 0, which must leave all outputs quiet. Together these two cases show that each cause is handled on its own and that neither hides the other.

// File: rtl/xu_pkg.sv
package xu_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LUI  = 6'h0F;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_ADDU, K_ADDI, K_OR, K_ORI, K_XOR, K_LUI
  } xu_kind_e;
endpackage

// File: rtl/xu_decode.sv
module xu_decode
  import xu_pkg::*;
#(
  parameter int IMM_W = 16
) (
  input  logic [INSTR_W-1:0] word,
  output xu_kind_e           kind,
  output logic [IDX_W-1:0]   dest,
  output logic [IMM_W-1:0]   imm
);
  logic [5:0]       opc, fn;
  logic [IDX_W-1:0] f_rt, f_rd;

  assign opc  = word[31:26];
  assign fn   = word[5:0];
  assign f_rt = word[20:16];
  assign f_rd = word[15:11];
  assign imm  = word[IMM_W-1:0];

  always_comb begin
    kind = K_NONE;
    dest = f_rt;
    unique case (opc)
      OPC_REG: begin
        dest = f_rd;
        case (fn)
          FN_ADD:  kind = K_ADD;
          FN_ADDU: kind = K_ADDU;
          FN_OR:   kind = K_OR;
          FN_XOR:  kind = K_XOR;
          default: kind = K_NONE;
        endcase
      end
      OPC_ADDI: kind = K_ADDI;
      OPC_ORI:  kind = K_ORI;
      OPC_LUI:  kind = K_LUI;
      default:  kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/xu_alu.sv
module xu_alu
  import xu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  xu_kind_e         kind,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  res,
  output logic             ovf
);
  localparam int PAD = XLEN - IMM_W;
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] imm_s, imm_z, imm_hi, addend, sum;
  logic            trap_kind;

  assign imm_s  = {{PAD{imm[IMM_W-1]}}, imm};
  assign imm_z  = {{PAD{1'b0}}, imm};
  assign imm_hi = {imm, {PAD{1'b0}}};

  assign addend    = (kind == K_ADDI) ? imm_s : b;
  assign sum       = a + addend;
  assign trap_kind = (kind == K_ADD) || (kind == K_ADDI);

  // signed overflow: operands agree in sign, sum disagrees
  assign ovf = trap_kind && (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    unique case (kind)
      K_ADD, K_ADDU, K_ADDI: res = sum;
      K_OR:                  res = a | b;
      K_ORI:                 res = a | imm_z;
      K_XOR:                 res = a ^ b;
      K_LUI:                 res = imm_hi;
      default:               res = '0;
    endcase
  end
endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import xu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    rs_data,
  input  logic [XLEN-1:0]    rt_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [XLEN-1:0]    wr_data,
  output logic               ovf
);
  xu_kind_e         kind;
  logic [IDX_W-1:0] dest;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  res;
  logic             alu_ovf, commit;

  xu_decode #(.IMM_W(IMM_W)) u_dec (
    .word(instr), .kind(kind), .dest(dest), .imm(imm)
  );

  xu_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
    .kind(kind), .a(rs_data), .b(rt_data), .imm(imm), .res(res), .ovf(alu_ovf)
  );

  assign commit = in_valid && (kind != K_NONE) && !alu_ovf && (dest != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      ovf     <= 1'b0;
    end else begin
      wr_en   <= commit;
      wr_idx  <= commit ? dest : '0;
      wr_data <= commit ? res : '0;
      ovf     <= in_valid && alu_ovf;
    end
  end

  // R2: idle cycle gives nothing
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !ovf));

  // R5: wrapping add never flags
  a_r5_addu_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == OPC_REG && instr[5:0] == FN_ADDU) |=> !ovf);

  // R9: upper-half load places imm high, zeros low
  a_r9_lui_shape: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == OPC_LUI && instr[20:16] != '0)
      |=> (wr_en && wr_data == {$past(instr[15:0]), 16'h0000}));

  // R10: overflow and write never coincide
  a_r10_ovf_no_write: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !wr_en);

  // R10: flag lasts one cycle unless a fresh instruction arrived
  a_r10_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
    (ovf && !in_valid) |=> !ovf);

  // R11: register 0 is never written
  a_r11_no_zero_dest: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != '0));

  // R12: all-zero word is inert
  a_r12_nop_inert: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr == '0) |=> (!wr_en && !ovf));

  // R13: data and index are zero without a write
  a_r13_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_data == '0 && wr_idx == '0));
endmodule

// File: tb/sim_xu_exec.sv
module sim_xu_exec;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, rs_data, rt_data;
  logic        wr_en, ovf;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  xu_exec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rs_data(rs_data), .rt_data(rt_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ovf(ovf)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] opc, input logic [4:0] rs, rt,
                                        input logic [15:0] im);
    return {opc, rs, rt, im};
  endfunction

  task automatic check(input string req, input logic e_we, input logic [4:0] e_idx,
                       input logic [31:0] e_dat, input logic e_ovf);
    total++;
    if (wr_en !== e_we || wr_idx !== e_idx || wr_data !== e_dat || ovf !== e_ovf) begin
      bad++;
      $display("FAIL %s: got we=%0b idx=%0d data=%h ovf=%0b, expected we=%0b idx=%0d data=%h ovf=%0b",
               req, wr_en, wr_idx, wr_data, ovf, e_we, e_idx, e_dat, e_ovf);
    end
  endtask

  // present one instruction, then sample its registered result
  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = w; rs_data = a; rt_data = b;
    @(negedge clk);
    in_valid = 1'b0; instr = 32'h0; rs_data = 32'h0; rt_data = 32'h0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1;
    instr = enc_i(6'h0F, 5'd0, 5'd4, 16'hFFFF); rs_data = '1; rt_data = '1;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 5'd0, 32'h0, 1'b0);
    rst = 1'b0; in_valid = 1'b0; instr = 32'h0; rs_data = 32'h0; rt_data = 32'h0;
    @(negedge clk);
  endtask

  task automatic t_add;
    issue(enc_r(5'd1, 5'd2, 5'd3, 6'h20), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R4 add neg", 1'b1, 5'd3, 32'hFFFF_FFFE, 1'b0);
    issue(enc_r(5'd1, 5'd2, 5'd7, 6'h20), 32'd1000, 32'd234);
    check("R3 R4 add rd", 1'b1, 5'd7, 32'd1234, 1'b0);
  endtask

  task automatic t_overflow;
    issue(enc_r(5'd1, 5'd2, 5'd3, 6'h20), 32'h7FFF_FFFF, 32'h1);
    check("R10 add ovf", 1'b0, 5'd0, 32'h0, 1'b1);
    @(negedge clk);
    check("R10 ovf one cycle", 1'b0, 5'd0, 32'h0, 1'b0);
    issue(enc_i(6'h08, 5'd1, 5'd5, 16'hFFFF), 32'h8000_0000, 32'h0);
    check("R6 addi ovf", 1'b0, 5'd0, 32'h0, 1'b1);
  endtask

  task automatic t_addu;
    issue(enc_r(5'd1, 5'd2, 5'd9, 6'h21), 32'h7FFF_FFFF, 32'h1);
    check("R5 addu no ovf", 1'b1, 5'd9, 32'h8000_0000, 1'b0);
    issue(enc_r(5'd1, 5'd2, 5'd9, 6'h21), 32'hFFFF_FFFF, 32'h2);
    check("R5 addu wrap", 1'b1, 5'd9, 32'h1, 1'b0);
  endtask

  task automatic t_addi;
    issue(enc_i(6'h08, 5'd1, 5'd6, 16'hFFFF), 32'd5, 32'hDEAD_0000);
    check("R6 R3 addi sext", 1'b1, 5'd6, 32'd4, 1'b0);
  endtask

  task automatic t_logic;
    issue(enc_r(5'd1, 5'd2, 5'd10, 6'h25), 32'hF0F0_0000, 32'h0000_0F0F);
    check("R7 or", 1'b1, 5'd10, 32'hF0F0_0F0F, 1'b0);
    issue(enc_r(5'd1, 5'd2, 5'd11, 6'h26), 32'hFF00_FF00, 32'h0FF0_0FF0);
    check("R7 xor", 1'b1, 5'd11, 32'hF0F0_F0F0, 1'b0);
    issue(enc_i(6'h0D, 5'd1, 5'd12, 16'h8001), 32'h1234_0000, 32'hFFFF_FFFF);
    check("R8 ori zext", 1'b1, 5'd12, 32'h1234_8001, 1'b0);
  endtask

  task automatic t_constant;
    logic [31:0] hi;
    issue(enc_i(6'h0F, 5'd0, 5'd4, 16'hDEAD), 32'h5555_5555, 32'h0);
    check("R9 lui", 1'b1, 5'd4, 32'hDEAD_0000, 1'b0);
    hi = wr_data;
    issue(enc_i(6'h0D, 5'd4, 5'd4, 16'hBEEF), hi, 32'h0);
    check("R9 lui+ori constant", 1'b1, 5'd4, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_zero_dest;
    issue(enc_r(5'd1, 5'd2, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h1);
    check("R11 r0 with ovf", 1'b0, 5'd0, 32'h0, 1'b1);
    @(negedge clk);
    check("R10 R11 flag dropped", 1'b0, 5'd0, 32'h0, 1'b0);
    issue(enc_i(6'h0F, 5'd0, 5'd0, 16'h1234), 32'h0, 32'h0);
    check("R11 R13 lui to r0", 1'b0, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_inert;
    issue(32'h0, 32'h1234_5678, 32'h1);
    check("R12 nop word", 1'b0, 5'd0, 32'h0, 1'b0);
    issue(enc_r(5'd1, 5'd2, 5'd3, 6'h22), 32'h7FFF_FFFF, 32'h1);
    check("R12 unknown funct", 1'b0, 5'd0, 32'h0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; instr = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    rs_data = 32'h7FFF_FFFF; rt_data = 32'h1;
    @(negedge clk);
    check("R2 idle ignores bus", 1'b0, 5'd0, 32'h0, 1'b0);
    instr = 32'h0; rs_data = 32'h0; rt_data = 32'h0;
  endtask

  initial begin
    t_reset();
    t_add();
    t_overflow();
    t_addu();
    t_addi();
    t_logic();
    t_constant();
    t_zero_dest();
    t_inert();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule